// File: doc/BRIEF.md
# H-Bridge Fault Supervisor with Timed Retry

This block supervises the digital fault flags of a driver with several H-bridges (two by default) and decides when each bridge must have all of its switches turned off. Every bridge has two current-limit flags, one for its high-side switches and one for its low-side switches. The driver also reports a die over-temperature flag and a supply undervoltage flag. The block produces one disable line for each bridge and a global reset for the rest of the driver logic. It reports nothing to the outside, and every recovery runs without outside help.

A current-limit flag on a bridge first passes a deglitch filter. Only a condition that lasts the whole filter window shuts that bridge down. The bridge then stays off for a fixed retry interval and switches back on by itself, and the other bridges are not affected. Over-temperature turns off all bridges for as long as the flag is present. The flag already carries the hysteresis of the temperature sensor. Undervoltage has the highest priority. It asynchronously clears every timer and state machine and turns off all bridges. The block leaves that reset synchronously once the supply is good again. The flags are asynchronous to `clk` and pass through a synchronizer `SYNC_STAGES` flops deep before any logic uses them.

Each bridge runs a state machine with three states:
- **RUN**: the bridge is on.
- **DEGLITCH**: an overcurrent is being timed.
- **RETRY_WAIT**: the bridge is held off.

The state machine has these transitions:
- **RUN→DEGLITCH**: the first overcurrent sample.
- **DEGLITCH→RUN**: the flag drops before the window ends.
- **DEGLITCH→RETRY_WAIT**: the deglitch window is complete.
- **RETRY_WAIT→RUN**: the interval ends and the flag is clear.
- **RETRY_WAIT→DEGLITCH**: the interval ends and the flag is still set.

Top module: `hb_fault_supervisor`

## Requirements
- R1: The flag of a bridge means the high-side flag OR the low-side flag after the synchronizer. A bridge is disabled only when that flag has been sampled high on `DEGLITCH_CYC` consecutive clock edges. The disable line rises `SYNC_STAGES + DEGLITCH_CYC` cycles after the raw flag rises. A pulse that is one cycle shorter never disables the bridge.
- R2: The deglitch count restarts whenever the flag is sampled low before the window completes. Two pulses of `DEGLITCH_CYC-1` cycles with one low cycle between them cause no shutdown.
- R3: A flag from the high side and a flag from the low side have the same effect.
- R4: An overcurrent shutdown disables only the bridge whose flag tripped. The disable lines of all other bridges stay low.
- R5: After an overcurrent trip, the disable line of the bridge stays high for exactly `RETRY_CYC` cycles. The bridge is then re-enabled without outside help.
- R6: If the flag is still present when the retry interval ends, the bridge goes back to DEGLITCH. Its disable line goes low for `DEGLITCH_CYC-1` cycles and then rises again.
- R7: Over-temperature raises every disable line `SYNC_STAGES` cycles after the raw flag rises. The lines fall `SYNC_STAGES` cycles after the flag clears, unless an overcurrent retry is still pending.
- R8: Undervoltage at once, without waiting for a clock edge, raises `logic_rst` and every disable line. It also clears every deglitch and retry state, so no retry in progress survives it.
- R9: `logic_rst` falls on the `SYNC_STAGES`-th rising clock edge after both `rst_n` is high and `uv_flag` is low.
- R10: During reset, `logic_rst` is 1 and every disable line is 1. After reset with no flags present, all disable lines are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous assert |
| uv_flag | input | 1 | Supply undervoltage, active high |
| ot_flag | input | 1 | Die over-temperature, active high |
| oc_hi | input | NB | High-side current-limit flag, one bit per bridge |
| oc_lo | input | NB | Low-side current-limit flag, one bit per bridge |
| bridge_off | output | NB | Disable of all switches of a bridge, one bit per bridge |
| logic_rst | output | 1 | Reset for the rest of the driver logic, active high |

## Verification
The bench measures how long it takes a bridge to trip, how long it stays off and how long the gap lasts before it trips again, each to the exact cycle. A bad state or count inside the block therefore shows at `bridge_off`:
- A counter that is not cleared trips the bridge on glitches that should be ignored.
- A retry timer that is off by one moves the re-enable edge by a cycle.
- A missing RETRY_WAIT→DEGLITCH transition leaves a bridge on when the flag persists.

Any of these shows up within one deglitch or retry window of the stimulus. A fault that spreads to the wrong bridge shows on the disable line of the quiet bridge during that same window. A state that survives undervoltage shows as a disable line that is still high two cycles after the supply recovers.

// File: rtl/hbfs_pkg.sv
`timescale 1ns/1ps
package hbfs_pkg;
    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_DEGLITCH   = 2'd1,
        ST_RETRY_WAIT = 2'd2
    } oc_state_e;
endpackage

// File: rtl/hbfs_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for asynchronous fault flags.
module hbfs_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbfs_rst_ctrl.sv
`timescale 1ns/1ps
// Global reset: asserted asynchronously by rst_n or undervoltage,
// released synchronously after STAGES clock edges.
module hbfs_rst_ctrl #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_flag,
    output logic int_rst_n
);
    logic              hold_n;
    logic [STAGES-1:0] chain;

    assign hold_n = rst_n & ~uv_flag;

    always_ff @(posedge clk or negedge hold_n) begin
        if (!hold_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign int_rst_n = chain[STAGES-1];
endmodule

// File: rtl/hb_oc_fsm.sv
`timescale 1ns/1ps
// Per-bridge overcurrent deglitch and retry state machine.
// DEGLITCH_CYC must be at least 2.
module hb_oc_fsm
    import hbfs_pkg::*;
#(
    parameter int DEGLITCH_CYC = 250,
    parameter int RETRY_CYC    = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_active,
    output logic retry_off
);
    localparam int MAX_CYC = (RETRY_CYC > DEGLITCH_CYC) ? RETRY_CYC : DEGLITCH_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] DEG_LAST   = CNT_W'(DEGLITCH_CYC - 1);
    localparam logic [CNT_W-1:0] RETRY_LAST = CNT_W'(RETRY_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    oc_state_e        state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // Transitions
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            ST_RUN: begin
                if (oc_active) begin
                    nxt_state = ST_DEGLITCH;
                    nxt_cnt   = CNT_ONE;
                end
            end
            ST_DEGLITCH: begin
                if (!oc_active) begin
                    nxt_state = ST_RUN;
                    nxt_cnt   = '0;
                end else if (cnt == DEG_LAST) begin
                    nxt_state = ST_RETRY_WAIT;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt + CNT_ONE;
                end
            end
            ST_RETRY_WAIT: begin
                if (cnt == RETRY_LAST) begin
                    if (oc_active) begin
                        nxt_state = ST_DEGLITCH;
                        nxt_cnt   = CNT_ONE;
                    end else begin
                        nxt_state = ST_RUN;
                        nxt_cnt   = '0;
                    end
                end else begin
                    nxt_cnt = cnt + CNT_ONE;
                end
            end
            default: begin
                nxt_state = ST_RUN;
                nxt_cnt   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        retry_off = (state == ST_RETRY_WAIT);
    end
endmodule

// File: rtl/hb_fault_supervisor.sv
`timescale 1ns/1ps
module hb_fault_supervisor #(
    parameter int NB           = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int DEGLITCH_CYC = 250,
    parameter int RETRY_CYC    = 125000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uv_flag,
    input  logic          ot_flag,
    input  logic [NB-1:0] oc_hi,
    input  logic [NB-1:0] oc_lo,
    output logic [NB-1:0] bridge_off,
    output logic          logic_rst
);
    localparam int FLAG_W = NB + 1;

    logic          int_rst_n;
    logic [NB-1:0] oc_sync;
    logic          ot_sync;
    logic [NB-1:0] retry_act;

    hbfs_rst_ctrl #(.STAGES(SYNC_STAGES)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .uv_flag   (uv_flag),
        .int_rst_n (int_rst_n)
    );

    hbfs_sync #(.STAGES(SYNC_STAGES), .WIDTH(FLAG_W)) u_sync (
        .clk   (clk),
        .rst_n (int_rst_n),
        .d     ({ot_flag, oc_hi | oc_lo}),
        .q     ({ot_sync, oc_sync})
    );

    for (genvar b = 0; b < NB; b++) begin : g_bridge
        hb_oc_fsm #(
            .DEGLITCH_CYC (DEGLITCH_CYC),
            .RETRY_CYC    (RETRY_CYC)
        ) u_fsm (
            .clk       (clk),
            .rst_n     (int_rst_n),
            .oc_active (oc_sync[b]),
            .retry_off (retry_act[b])
        );
    end

    assign bridge_off = retry_act | {NB{ot_sync | ~int_rst_n}};
    assign logic_rst  = ~int_rst_n;
endmodule

// File: rtl/hb_fault_supervisor_chk.sv
`timescale 1ns/1ps
module hb_fault_supervisor_chk #(
    parameter int NB        = 2,
    parameter int RETRY_CYC = 125000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          uv_flag,
    input logic          int_rst_n,
    input logic [NB-1:0] oc_sync,
    input logic          ot_sync,
    input logic [NB-1:0] retry_act,
    input logic [NB-1:0] bridge_off,
    input logic          logic_rst
);
    for (genvar b = 0; b < NB; b++) begin : g_b
        logic [31:0] run_len;

        always_ff @(posedge clk or negedge int_rst_n) begin
            if (!int_rst_n)        run_len <= '0;
            else if (retry_act[b]) run_len <= run_len + 32'd1;
            else                   run_len <= '0;
        end

        // R1: a bridge can enter its off window only on a sampled overcurrent
        a_r1_trip_needs_oc: assert property (@(posedge clk) disable iff (!int_rst_n)
            $rose(retry_act[b]) |-> $past(oc_sync[b]));

        // R5: each off window lasts exactly RETRY_CYC cycles
        a_r5_retry_length: assert property (@(posedge clk) disable iff (!int_rst_n)
            $fell(retry_act[b]) |-> (run_len == RETRY_CYC));

        // R6: leaving the window with overcurrent present does not enable unfiltered
        a_r6_no_instant_retrip: assert property (@(posedge clk) disable iff (!int_rst_n)
            $fell(retry_act[b]) |=> !retry_act[b]);
    end

    // R7: over-temperature turns off every bridge
    a_r7_ot_all_off: assert property (@(posedge clk) disable iff (!int_rst_n)
        ot_sync |-> (&bridge_off));

    // R8: undervoltage always holds the global reset
    a_r8_uv_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |-> logic_rst);

    // R10: while in reset all bridges are off
    a_r10_reset_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        logic_rst |-> (&bridge_off));
endmodule

bind hb_fault_supervisor hb_fault_supervisor_chk #(
    .NB        (NB),
    .RETRY_CYC (RETRY_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .uv_flag    (uv_flag),
    .int_rst_n  (int_rst_n),
    .oc_sync    (oc_sync),
    .ot_sync    (ot_sync),
    .retry_act  (retry_act),
    .bridge_off (bridge_off),
    .logic_rst  (logic_rst)
);

// File: tb/test_hb_fault_supervisor.sv
`timescale 1ns/1ps
module test_hb_fault_supervisor;
    localparam int NB    = 2;
    localparam int SYNC  = 2;
    localparam int DEG   = 8;
    localparam int RETRY = 40;
    localparam int TRIP  = SYNC + DEG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          uv_flag = 1'b0;
    logic          ot_flag = 1'b0;
    logic [NB-1:0] oc_hi = '0;
    logic [NB-1:0] oc_lo = '0;
    logic [NB-1:0] bridge_off;
    logic          logic_rst;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    hb_fault_supervisor #(
        .NB(NB), .SYNC_STAGES(SYNC), .DEGLITCH_CYC(DEG), .RETRY_CYC(RETRY)
    ) i_hb_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .ot_flag(ot_flag),
        .oc_hi(oc_hi), .oc_lo(oc_lo), .bridge_off(bridge_off), .logic_rst(logic_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_oc(input int b, input bit lo, input bit v);
        if (lo) oc_lo[b] = v;
        else    oc_hi[b] = v;
    endtask

    // Drives a flag pattern on bridge b and records disable timing.
    // Level for edge j: high for j in [1,hold], and if reps==2 also in
    // [hold+gap+1, 2*hold+gap]. Sample k is taken after edge k.
    task automatic run_pattern(input int b, input bit lo, input int hold, input int gap,
                               input int reps, input int total,
                               output int first_on, output int on_cnt,
                               output int second_on, output int other_on);
        bit seen_low_after;
        first_on = 0; on_cnt = 0; second_on = 0; other_on = 0;
        seen_low_after = 1'b0;
        for (int k = 0; k <= total; k++) begin
            if (k > 0) begin
                tick();
                if (bridge_off[b]) begin
                    if (first_on == 0) first_on = k;
                    else if (seen_low_after && second_on == 0) second_on = k;
                    if (second_on == 0) on_cnt++;
                end else if (first_on != 0) begin
                    seen_low_after = 1'b1;
                end
                for (int o = 0; o < NB; o++)
                    if (o != b && bridge_off[o]) other_on++;
            end
            begin
                int j = k + 1;
                bit lvl = (j <= hold) ||
                          (reps == 2 && j > hold + gap && j <= 2 * hold + gap);
                set_oc(b, lo, lvl);
            end
        end
        set_oc(b, lo, 1'b0);
        repeat (RETRY + DEG + 8) tick();
    endtask

    task automatic t_reset();
        #1;
        chk("R10 logic_rst in reset", logic_rst, 1);
        chk("R10 bridge_off in reset", bridge_off, 2'b11);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R9 logic_rst one edge after release", logic_rst, 1);
        tick();
        chk("R9 logic_rst released", logic_rst, 0);
        chk("R10 bridges on after reset", bridge_off, 2'b00);
    endtask

    task automatic t_short_pulse();
        int f, c, s, o;
        run_pattern(0, 1'b0, DEG - 1, 0, 1, 60, f, c, s, o);
        chk("R1 short pulse ignored", f, 0);
    endtask

    task automatic t_restart();
        int f, c, s, o;
        run_pattern(1, 1'b1, DEG - 1, 1, 2, 60, f, c, s, o);
        chk("R2 counter clears between pulses", f, 0);
    endtask

    task automatic t_trip(input int b, input bit lo, input string tag);
        int f, c, s, o;
        run_pattern(b, lo, DEG, 0, 1, 70, f, c, s, o);
        chk({tag, " R1 trip latency"}, f, TRIP);
        chk({tag, " R5 off duration"}, c, RETRY);
        chk({tag, " R4 other bridge untouched"}, o, 0);
    endtask

    task automatic t_persist();
        int f, c, s, o;
        run_pattern(1, 1'b0, 70, 0, 1, 70, f, c, s, o);
        chk("R6 first trip", f, TRIP);
        chk("R6 first off window", c, RETRY);
        chk("R6 re-trip after deglitch", s, TRIP + RETRY + DEG - 1);
        chk("R6 R4 other bridge untouched", o, 0);
    endtask

    task automatic t_overtemp();
        ot_flag = 1'b1;
        tick();
        chk("R7 not yet off", bridge_off, 2'b00);
        tick();
        chk("R7 all off", bridge_off, 2'b11);
        repeat (5) tick();
        ot_flag = 1'b0;
        tick();
        chk("R7 still off", bridge_off, 2'b11);
        tick();
        chk("R7 resumed", bridge_off, 2'b00);
    endtask

    task automatic t_undervoltage();
        int stuck;
        oc_hi[0] = 1'b1;
        repeat (DEG) tick();
        oc_hi[0] = 1'b0;
        repeat (SYNC + 3) tick();
        chk("R8 bridge 0 in retry before uv", bridge_off, 2'b01);
        #2 uv_flag = 1'b1;
        #1;
        chk("R8 logic_rst immediate", logic_rst, 1);
        chk("R8 all off immediate", bridge_off, 2'b11);
        @(negedge clk);
        repeat (3) tick();
        uv_flag = 1'b0;
        tick();
        chk("R9 held one edge after uv", logic_rst, 1);
        tick();
        chk("R9 released after uv", logic_rst, 0);
        stuck = 0;
        for (int k = 0; k < RETRY; k++) begin
            if (bridge_off != 2'b00) stuck++;
            tick();
        end
        chk("R8 retry state cleared by uv", stuck, 0);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_short_pulse();
        t_restart();
        t_trip(0, 1'b1, "R3 low-side");
        t_trip(0, 1'b0, "R3 high-side");
        t_persist();
        t_overtemp();
        t_undervoltage();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule